// File: doc/BRIEF.md
# Scatter-Gather Bus-Master DMA Engine

This block moves words between system memory and a storage device. It does not use a single address and length pair. It follows a list of region descriptors that software leaves in memory. Software writes the list address and a direction into a small register file, then sets a go bit. The engine reads the first descriptor over a plain memory read port and keeps its base and length in working registers that software cannot see. It then answers the device's DMA requests with acknowledges and moves one word for each handshake. When a region is used up, the engine reads the next descriptor. It stops after the region whose descriptor carries the end-of-list flag.

Each descriptor is two words. Word 0 is the region base address. Word 1 holds the byte length in bits 15:0 and the end-of-list flag in bit 31. The memory port is a synchronous port with read data one cycle after a sampled read request, the same timing as a block RAM. The device side is a plain request/acknowledge pair. Either side can hold the transfer back for any number of cycles.

Top module: `sg_dma`

## Requirements
- R1: After reset the status word reads 0, and `dev_ack` and `mem_req` are low.
- R2: Writing the command register (address 0) with bit 0 set starts a transfer, provided the engine is inactive and the pointer is word aligned. The start clears fault (status bit 1) and irq (status bit 2) and sets active (status bit 0). The first two memory reads then go to the pointer and to the pointer plus 4.
- R3: If the pointer's low two bits are nonzero when a start is written, fault is set, active stays 0 and no memory request is issued.
- R4: `dev_ack` is high only while active, and only after both words of the first descriptor have been read.
- R5: With command bit 1 set (device to memory), each handshake writes `dev_wdata` to the next word address of the current region. A handshake is `dev_ack` and `dev_req` both high at a rising edge. Addresses start at the region base with its low two bits forced to 0 and step by 4.
- R6: With command bit 1 clear (memory to device), each handshake delivers on `dev_rdata` the memory word at the next word address of the current region.
- R7: A region holds byte length / 4 words, with the low two length bits ignored. A length field of 0 means 65536 bytes.
- R8: Descriptors are read at 8-byte steps. The pointer advances only in its low 16 bits, so a list wraps inside its 64 KB page.
- R9: Holding `dev_req` low for any number of cycles mid-region loses, repeats and reorders no word.
- R10: After the last word of an end-of-list region, active clears, irq sets and `dev_ack` stays low whatever `dev_req` does.
- R11: Clearing command bit 0 during a transfer stops the engine after the word in flight. After that there are no further handshakes and no memory requests, active clears and irq stays 0.
- R12: Register map: 0 is the command register, 1 is status (bits 1 and 2 are cleared by writing 1), and 2 is the list pointer. `reg_rdata` shows the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read request |
| dev_req | input | 1 | Device DMA request |
| dev_ack | output | 1 | DMA acknowledge; handshake when high with dev_req |
| dev_wdata | input | 32 | Word from the device (device to memory) |
| dev_rdata | output | 32 | Word to the device (memory to device) |

## Verification
A wrong working base or count shows at the memory port as soon as the engine issues the next write or read, one cycle after the handshake that uses it. A wrong count shows as a descriptor read that comes one word early or late. A list-walk error shows as a descriptor read at an unexpected address right after a region closes. A lost end-of-list or halt decision shows within a cycle as an acknowledge that is still high, a further handshake, or a missing irq bit.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DESC_A,
    ST_DESC_B,
    ST_DESC_W0,
    ST_DESC_W1,
    ST_RD_ISSUE,
    ST_RD_WAIT,
    ST_RD_CATCH,
    ST_OFFER
  } eng_state_t;

  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_TBL  = 2'd2;

  localparam int CMD_GO_BIT    = 0;
  localparam int CMD_TOMEM_BIT = 1;

  localparam int STAT_ACT_BIT   = 0;
  localparam int STAT_FAULT_BIT = 1;
  localparam int STAT_IRQ_BIT   = 2;

endpackage

// File: rtl/sg_dma_regs.sv
module sg_dma_regs
  import sg_dma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              fin_i,
  input  logic              halt_i,
  output logic              go,
  output logic              run,
  output logic              to_mem,
  output logic [DATA_W-1:0] tbl_ptr,
  output logic              active,
  output logic              fault,
  output logic              irq
);

  logic [DATA_W-1:0] rd_mux;
  logic              start_wr;

  assign start_wr = reg_wr && (reg_addr == RA_CMD) && reg_wdata[CMD_GO_BIT];

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_CMD: begin
        rd_mux[CMD_GO_BIT]    = run;
        rd_mux[CMD_TOMEM_BIT] = to_mem;
      end
      RA_STAT: begin
        rd_mux[STAT_ACT_BIT]   = active;
        rd_mux[STAT_FAULT_BIT] = fault;
        rd_mux[STAT_IRQ_BIT]   = irq;
      end
      RA_TBL:  rd_mux = tbl_ptr;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      go        <= 1'b0;
      run       <= 1'b0;
      to_mem    <= 1'b0;
      tbl_ptr   <= '0;
      active    <= 1'b0;
      fault     <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      go        <= 1'b0;
      reg_rdata <= rd_mux;
      if (fin_i || halt_i) active <= 1'b0;
      if (fin_i) irq <= 1'b1;
      if (reg_wr) begin
        case (reg_addr)
          RA_CMD: begin
            run <= reg_wdata[CMD_GO_BIT];
            if (!active) to_mem <= reg_wdata[CMD_TOMEM_BIT];
          end
          RA_STAT: begin
            if (reg_wdata[STAT_FAULT_BIT]) fault <= 1'b0;
            if (reg_wdata[STAT_IRQ_BIT])   irq   <= 1'b0;
          end
          RA_TBL:  tbl_ptr <= reg_wdata;
          default: ;
        endcase
      end
      if (start_wr && !active) begin
        if (tbl_ptr[1:0] != 2'b00) begin
          fault <= 1'b1;
        end else begin
          fault  <= 1'b0;
          irq    <= 1'b0;
          active <= 1'b1;
          go     <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sg_dma_region.sv
module sg_dma_region #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_base,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic              ld_eol,
  input  logic              step,
  output logic [DATA_W-1:0] cur_base,
  output logic              is_last,
  output logic              is_eol
);

  localparam int WB   = DATA_W / 8;
  localparam int WSH  = $clog2(WB);
  localparam int FW   = CNT_W - WSH;
  localparam int WC_W = FW + 1;

  logic [WC_W-1:0] left;
  logic [FW-1:0]   fld;
  logic [WC_W-1:0] ld_words;
  logic            unused_lo;

  assign fld       = ld_cnt[CNT_W-1:WSH];
  assign ld_words  = (fld == '0) ? (WC_W'(1) << FW) : {1'b0, fld};
  assign is_last   = (left == WC_W'(1));
  assign unused_lo = ^{ld_cnt[WSH-1:0], ld_base[WSH-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_base <= '0;
      left     <= '0;
      is_eol   <= 1'b0;
    end else if (load) begin
      cur_base <= {ld_base[DATA_W-1:WSH], {WSH{1'b0}}};
      left     <= ld_words;
      is_eol   <= ld_eol;
    end else if (step) begin
      cur_base <= cur_base + DATA_W'(WB);
      left     <= left - WC_W'(1);
    end
  end

endmodule

// File: rtl/sg_dma_fsm.sv
module sg_dma_fsm
  import sg_dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              run,
  input  logic              to_mem,
  input  logic [DATA_W-1:0] tbl_ptr,
  output logic              fin,
  output logic              halt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dev_req,
  output logic              dev_ack,
  input  logic [DATA_W-1:0] dev_wdata,
  output logic [DATA_W-1:0] dev_rdata,
  output logic              rg_load,
  output logic [DATA_W-1:0] rg_base,
  output logic [CNT_W-1:0]  rg_cnt,
  output logic              rg_eol,
  output logic              rg_step,
  input  logic [DATA_W-1:0] cur_base,
  input  logic              is_last,
  input  logic              is_eol
);

  localparam int WB         = DATA_W / 8;
  localparam int DESC_BYTES = 2 * WB;

  eng_state_t        state;
  logic [DATA_W-1:0] walk;
  logic [DATA_W-1:0] desc_base;
  logic              dir_wr;
  logic              beat;

  assign beat    = (state == ST_OFFER) && dev_ack && dev_req;
  assign rg_step = beat;
  assign rg_load = (state == ST_DESC_W1);
  assign rg_base = desc_base;
  assign rg_cnt  = mem_rdata[CNT_W-1:0];
  assign rg_eol  = mem_rdata[DATA_W-1];
  assign fin     = beat && is_last && is_eol;
  assign halt    = (state != ST_IDLE) && !run;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      walk      <= '0;
      desc_base <= '0;
      dir_wr    <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      dev_ack   <= 1'b0;
      dev_rdata <= '0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      case (state)
        ST_IDLE: begin
          dev_ack <= 1'b0;
          if (go) begin
            walk   <= tbl_ptr;
            dir_wr <= to_mem;
            state  <= ST_DESC_A;
          end
        end
        ST_DESC_A: begin
          mem_req  <= 1'b1;
          mem_addr <= walk;
          state    <= ST_DESC_B;
        end
        ST_DESC_B: begin
          mem_req  <= 1'b1;
          mem_addr <= {walk[DATA_W-1:PAGE_W], walk[PAGE_W-1:0] + PAGE_W'(WB)};
          state    <= ST_DESC_W0;
        end
        ST_DESC_W0: begin
          desc_base <= mem_rdata;
          state     <= ST_DESC_W1;
        end
        ST_DESC_W1: begin
          walk <= {walk[DATA_W-1:PAGE_W], walk[PAGE_W-1:0] + PAGE_W'(DESC_BYTES)};
          if (dir_wr) begin
            dev_ack <= 1'b1;
            state   <= ST_OFFER;
          end else begin
            state <= ST_RD_ISSUE;
          end
        end
        ST_RD_ISSUE: begin
          mem_req  <= 1'b1;
          mem_addr <= cur_base;
          state    <= ST_RD_WAIT;
        end
        ST_RD_WAIT: state <= ST_RD_CATCH;
        ST_RD_CATCH: begin
          dev_rdata <= mem_rdata;
          dev_ack   <= 1'b1;
          state     <= ST_OFFER;
        end
        ST_OFFER: begin
          if (beat) begin
            if (dir_wr) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= cur_base;
              mem_wdata <= dev_wdata;
            end
            if (is_last) begin
              dev_ack <= 1'b0;
              state   <= is_eol ? ST_IDLE : ST_DESC_A;
            end else if (!dir_wr) begin
              dev_ack <= 1'b0;
              state   <= ST_RD_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (halt) begin
        state   <= ST_IDLE;
        dev_ack <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sg_dma.sv
module sg_dma
  import sg_dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dev_req,
  output logic              dev_ack,
  input  logic [DATA_W-1:0] dev_wdata,
  output logic [DATA_W-1:0] dev_rdata
);

  logic              go, run, to_mem, fin, halt;
  logic              st_active, st_fault, st_irq;
  logic [DATA_W-1:0] tbl_ptr;
  logic              rg_load, rg_eol, rg_step, is_last, is_eol;
  logic [DATA_W-1:0] rg_base, cur_base;
  logic [CNT_W-1:0]  rg_cnt;

  sg_dma_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fin_i(fin), .halt_i(halt),
    .go(go), .run(run), .to_mem(to_mem), .tbl_ptr(tbl_ptr),
    .active(st_active), .fault(st_fault), .irq(st_irq)
  );

  sg_dma_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk(clk), .rst(rst), .go(go), .run(run), .to_mem(to_mem), .tbl_ptr(tbl_ptr),
    .fin(fin), .halt(halt), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_req(dev_req), .dev_ack(dev_ack), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata), .rg_load(rg_load), .rg_base(rg_base),
    .rg_cnt(rg_cnt), .rg_eol(rg_eol), .rg_step(rg_step),
    .cur_base(cur_base), .is_last(is_last), .is_eol(is_eol)
  );

  sg_dma_region #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_region (
    .clk(clk), .rst(rst), .load(rg_load), .ld_base(rg_base), .ld_cnt(rg_cnt),
    .ld_eol(rg_eol), .step(rg_step), .cur_base(cur_base),
    .is_last(is_last), .is_eol(is_eol)
  );

endmodule

// File: rtl/sg_dma_chk.sv
module sg_dma_chk (
  input logic       clk,
  input logic       rst,
  input logic       dev_ack,
  input logic       mem_req,
  input logic       active,
  input logic       fault,
  input logic       irq,
  input logic       go,
  input logic       start_wr,
  input logic [1:0] tbl_low
);

  AST_ACK_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    dev_ack |-> active); // R4

  AST_GO_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    go |-> (active && !fault && !irq)); // R2

  AST_MISALIGN_FAULT: assert property (@(posedge clk) disable iff (rst)
    (start_wr && !active && (tbl_low != 2'b00)) |=> (fault && !active)); // R3

  AST_FALL_DROPS_ACK: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> !dev_ack); // R10

  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $fell(active)); // R10

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!active && !$past(active)) |-> !mem_req); // R11

endmodule

bind sg_dma sg_dma_chk u_chk (
  .clk(clk), .rst(rst), .dev_ack(dev_ack), .mem_req(mem_req),
  .active(st_active), .fault(st_fault), .irq(st_irq), .go(go),
  .start_wr(reg_wr && (reg_addr == 2'd0) && reg_wdata[0]),
  .tbl_low(tbl_ptr[1:0])
);

// File: tb/tb_sg_dma.sv
module tb_sg_dma;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 32'd0;
  logic        dev_req, dev_ack;
  logic [31:0] dev_wdata, dev_rdata;

  always #5 clk = ~clk;

  sg_dma dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dev_req(dev_req), .dev_ack(dev_ack),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: descriptor words in a sparse store, data words derived from address
  logic [31:0] dmem [logic [31:0]];
  function automatic logic [31:0] pat(input logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h0F0F_0000;
  endfunction
  function automatic logic [31:0] wpat(input int k);
    return 32'hD00D_0000 + k;
  endfunction
  always @(posedge clk)
    if (mem_req && !mem_we)
      mem_rdata <= dmem.exists(mem_addr) ? dmem[mem_addr] : pat(mem_addr);

  // expected regions
  logic [31:0] rb [0:2];
  int          rw [0:2];
  int          nreg;
  bit          ex_tomem;

  function automatic logic [31:0] exp_addr(input int k);
    int j = k;
    for (int r = 0; r < nreg; r++) begin
      if (j < rw[r]) return rb[r] + 32'(4 * j);
      j -= rw[r];
    end
    return 32'hFFFF_FFFF;
  endfunction

  // device model
  bit req_en = 0;
  bit stall = 0;
  int cyc = 0;
  always @(negedge clk) cyc <= cyc + 1;
  assign dev_req = req_en && (!stall || ((cyc % 3) != 2));

  int nbeat = 0, nwr = 0, ndr = 0, nreq = 0;
  logic [31:0] dreads [0:7];
  bit clr = 0;
  assign dev_wdata = wpat(nbeat);

  always @(posedge clk) begin
    if (clr) begin
      nbeat <= 0; nwr <= 0; ndr <= 0; nreq <= 0;
    end else if (!rst) begin
      if (mem_req) nreq <= nreq + 1;
      if (mem_req && !mem_we && dmem.exists(mem_addr)) begin
        if (ndr < 8) dreads[ndr] <= mem_addr;
        ndr <= ndr + 1;
      end
      if (dev_ack) chk(ndr >= 2, "R4 ack before descriptor", 32'(ndr), 32'd2);
      if (dev_ack && dev_req) begin
        if (!ex_tomem) chk(dev_rdata == pat(exp_addr(nbeat)), "R6 R9 read word", dev_rdata, pat(exp_addr(nbeat)));
        nbeat <= nbeat + 1;
      end
      if (mem_req && mem_we) begin
        chk(mem_addr == exp_addr(nwr), "R5 R9 write address", mem_addr, exp_addr(nwr));
        chk(mem_wdata == wpat(nwr), "R5 R9 write data", mem_wdata, wpat(nwr));
        nwr <= nwr + 1;
      end
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic clear_counts();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] ptr, input int idx, input logic [31:0] base,
                          input logic [15:0] bytes, input bit eol);
    logic [31:0] a;
    a = {ptr[31:16], ptr[15:0] + 16'(idx * 8)};
    dmem[a] = base;
    dmem[{a[31:16], a[15:0] + 16'd4}] = {eol, 15'd0, bytes};
    rb[idx] = base & 32'hFFFF_FFFC;
    rw[idx] = (bytes[15:2] == 14'd0) ? 16384 : int'(bytes[15:2]);
  endtask

  task automatic table3(input logic [31:0] ptr);
    dmem.delete();
    put_desc(ptr, 0, 32'h0000_2000, 16'd16, 1'b0);
    put_desc(ptr, 1, 32'h0000_3000, 16'd8,  1'b0);
    put_desc(ptr, 2, 32'h0000_4006, 16'd14, 1'b1);
    nreg = 3;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 40000; i++) begin
      reg_read(2'd1, s);
      if (!s[0]) break;
    end
  endtask

  task automatic run_list(input logic [31:0] ptr, input bit tomem, input bit stl, input string tag);
    logic [31:0] s;
    int total = 0;
    for (int r = 0; r < nreg; r++) total += rw[r];
    ex_tomem = tomem;
    stall = stl;
    clear_counts();
    req_en = 1'b1;
    reg_write(2'd2, ptr);
    reg_write(2'd0, {30'd0, tomem, 1'b1});
    reg_read(2'd1, s);
    chk(s[2:0] == 3'b001, "R2 start flags", s, 32'h1);
    wait_idle();
    @(negedge clk);
    chk(nbeat == total, {tag, " R7 handshake count"}, 32'(nbeat), 32'(total));
    if (tomem) chk(nwr == total, {tag, " R5 write count"}, 32'(nwr), 32'(total));
    chk(ndr == 2 * nreg, {tag, " R8 descriptor reads"}, 32'(ndr), 32'(2 * nreg));
    chk(dreads[0] == ptr, "R2 first descriptor read", dreads[0], ptr);
    chk(dreads[1] == ptr + 32'd4, "R2 second descriptor read", dreads[1], ptr + 32'd4);
    reg_read(2'd1, s);
    chk(s == 32'h4, {tag, " R10 final status"}, s, 32'h4);
    stall = 1'b0;
    repeat (8) @(negedge clk);
    chk(nbeat == total, {tag, " R10 requests masked"}, 32'(nbeat), 32'(total));
    chk(dev_ack == 1'b0, {tag, " R10 ack low"}, 32'(dev_ack), 32'h0);
    req_en = 1'b0;
    reg_write(2'd0, {30'd0, tomem, 1'b0});
  endtask

  initial begin
    logic [31:0] s;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(dev_ack == 1'b0, "R1 dev_ack", 32'(dev_ack), 32'h0);
    chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'h0);
    reg_read(2'd1, s);
    chk(s == 32'h0, "R1 status", s, 32'h0);

    // R3 misaligned pointer, R12 readback and write-one-to-clear
    dmem.delete();
    clear_counts();
    reg_write(2'd2, 32'h0000_1002);
    reg_write(2'd0, 32'h1);
    reg_read(2'd1, s);
    chk(s == 32'h2, "R3 fault set, inactive", s, 32'h2);
    repeat (10) @(negedge clk);
    chk(nreq == 0, "R3 no memory request", 32'(nreq), 32'h0);
    reg_read(2'd2, s);
    chk(s == 32'h0000_1002, "R12 pointer readback", s, 32'h0000_1002);
    reg_read(2'd0, s);
    chk(s == 32'h1, "R12 command readback", s, 32'h1);
    reg_write(2'd1, 32'h2);
    reg_read(2'd1, s);
    chk(s == 32'h0, "R12 fault cleared by write one", s, 32'h0);
    reg_write(2'd0, 32'h0);

    // R5 device to memory, no stall
    table3(32'h0000_1000);
    run_list(32'h0000_1000, 1'b1, 1'b0, "wr");
    // R9 device to memory with stalls; R2 irq from last run cleared at start
    run_list(32'h0000_1000, 1'b1, 1'b1, "wr-stall");
    // R6 memory to device with stalls
    run_list(32'h0000_1000, 1'b0, 1'b1, "rd-stall");

    // R8 list wraps inside its 64 KB page
    dmem.delete();
    put_desc(32'h0000_FFF0, 0, 32'h0000_5000, 16'd4, 1'b0);
    put_desc(32'h0000_FFF0, 1, 32'h0000_6000, 16'd8, 1'b0);
    put_desc(32'h0000_FFF0, 2, 32'h0000_7000, 16'd4, 1'b1);
    nreg = 3;
    run_list(32'h0000_FFF0, 1'b1, 1'b0, "wrap");
    chk(dreads[4] == 32'h0, "R8 wrapped descriptor word 0", dreads[4], 32'h0);
    chk(dreads[5] == 32'h4, "R8 wrapped descriptor word 1", dreads[5], 32'h4);

    // R7 zero length field means 64 KB
    dmem.delete();
    put_desc(32'h0000_1000, 0, 32'h0000_8000, 16'd0, 1'b1);
    nreg = 1;
    run_list(32'h0000_1000, 1'b1, 1'b0, "zero-len");
    chk(rw[0] == 16384, "R7 full page words", 32'(rw[0]), 32'd16384);

    // R11 halt mid-region
    table3(32'h0000_1000);
    ex_tomem = 1'b1;
    stall = 1'b0;
    clear_counts();
    reg_write(2'd2, 32'h0000_1000);
    reg_write(2'd0, 32'h3);
    req_en = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (nbeat >= 3) break;
    end
    req_en = 1'b0;
    reg_write(2'd0, 32'h2);
    repeat (5) @(negedge clk);
    req_en = 1'b1;
    repeat (10) @(negedge clk);
    chk(nbeat == 3, "R11 no handshake after halt", 32'(nbeat), 32'd3);
    chk(nwr == 3, "R11 no write after halt", 32'(nwr), 32'd3);
    chk(dev_ack == 1'b0, "R11 ack low", 32'(dev_ack), 32'h0);
    reg_read(2'd1, s);
    chk(s == 32'h0, "R11 status after halt", s, 32'h0);
    req_en = 1'b0;

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd200000, 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule